// File: doc/BRIEF.md
# Multi-Mode Programmable Interval Counter Channel

This block is one down-counter channel of a programmable interval timer. A host writes a mode control word and then an initial count of one or two bytes. The channel moves that count into its counting element and counts down on counter clock pulses. It drives a single output whose waveform depends on the mode: an interrupt on terminal count, a hardware-triggered one-shot, a rate generator, a software-triggered strobe or a hardware-triggered strobe. Counting can be plain binary or four-digit decimal (BCD).

The block runs on one system clock. Each completed pulse of the counter clock arrives as a one-cycle strobe, `cnt_tick`. The count is loaded or decremented on that strobe, and the gate level is sampled on it. A gate rising edge is synchronised into the system clock and caught in an edge flag, which the next tick consumes and clears, so a short gate pulse between ticks still counts as a trigger. The channel also brings out the live count for an external read latch, and a null-count flag that shows a written count is still waiting to be moved into the counting element.

Top module: `pit_channel`

## Requirements
- R1: A control-word write takes effect on the next system clock with no tick needed. It sets OUT low for mode code 0 and high for every other code, stops counting, and forgets any earlier count. Codes 3, 6 and 7 are reserved: the channel then holds OUT high and does not count.
- R2: The access code picks the count byte format. Code 2 takes one byte as the high byte, with the low byte zero. Code 3 takes the low byte and then the high byte. Codes 0 and 1 take one byte as the low byte, with the high byte zero. In modes 0, 2 and 4, the tick after a complete count write copies the count into the counting element without decrementing it.
- R3: Mode 0: OUT goes high on the tick that brings the count to zero, which is tick N+1 after the write. It stays high as the counter wraps. While the gate level is low at a tick, the count holds.
- R4: Mode 0 with two-byte access: writing the low byte drives OUT low at once and freezes the count. Writing the high byte lets the new count load on the next tick.
- R5: Mode 1: the first tick after a gate rising edge loads the count and drives OUT low. OUT returns high N ticks later. A count written after that is used only when the next trigger arrives; until then counting goes on from the old value.
- R6: Mode 2: OUT is low for the one tick on which the count reaches 1. The next tick reloads the count and raises OUT, so the period is N ticks. A low gate forces OUT high without a tick and holds the count. A gate rising edge reloads the count on the next tick.
- R7: Mode 4: counting starts when the count is written. OUT goes low for exactly one tick on tick N+1 after the write, once per loaded count.
- R8: Mode 5: counting starts on the first tick after a gate rising edge. OUT goes low for one tick N ticks after that loading tick.
- R9: A count of 0 gives the full range: after loading it, the next decrement gives FFFF in binary or 9999 in BCD, and counting continues.
- R10: With BCD selected, each of the four 4-bit digits counts down 9 to 0, borrowing from the next digit (for example 0100 then 0099).
- R11: `null_cnt` is set by a control-word write and by a complete count write (for two-byte access, only after the high byte). It is cleared when the count moves into the counting element.
- R12: A gate rising edge is remembered until the next tick, even if the gate falls again before that tick.
- R13: `live_count` shows the counting element and changes only on a tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cw_wr | input | 1 | Control-word write strobe |
| cw_mode | input | 3 | Mode code written with the control word |
| cw_bcd | input | 1 | 1 selects BCD counting |
| cw_access | input | 2 | Count byte access code |
| cnt_wr | input | 1 | Count byte write strobe |
| cnt_data | input | 8 | Count byte |
| cnt_tick | input | 1 | One-cycle strobe per counter clock pulse |
| gate | input | 1 | Gate input, asynchronous |
| out | output | 1 | Counter output |
| null_cnt | output | 1 | Written count not yet in the counting element |
| live_count | output | 16 | Current counting element value |

## Verification
The bench goes after the load tick that must not decrement. A design that decrements on that tick raises the mode 0 output one tick early and shortens the mode 4 and mode 5 strobe delays. It checks that a low byte of a two-byte count freezes the counter and pulls the output low at once. A design that misses this keeps counting, or leaves the output high, until the high byte arrives. It also covers the mode 2 reload and gate behaviour, the wrap from zero in both number systems, the BCD borrow across digits, and a gate pulse that ends before the tick. An off-by-one in the reload shows up as a wrong period. A gate handled as a level instead of an edge loses the short trigger. A decimal borrow done as binary subtraction gives 00FF instead of 0099.

// File: rtl/pit_pkg.sv
`timescale 1ns/1ps
// Shared encodings for the interval counter channel.
package pit_pkg;
    typedef enum logic [2:0] {
        MD_TERM     = 3'd0,
        MD_ONESHOT  = 3'd1,
        MD_RATE     = 3'd2,
        MD_RSV3     = 3'd3,
        MD_SWSTROBE = 3'd4,
        MD_HWSTROBE = 3'd5,
        MD_RSV6     = 3'd6,
        MD_RSV7     = 3'd7
    } pit_mode_e;

    typedef enum logic [1:0] {
        AC_LOW0 = 2'd0,
        AC_LOW  = 2'd1,
        AC_HIGH = 2'd2,
        AC_BOTH = 2'd3
    } pit_access_e;
endpackage

// File: rtl/pit_gate_capture.sv
`timescale 1ns/1ps
// Gate front end. It synchronises the asynchronous gate into clk and keeps a
// rising-edge flag. The flag stays set until a tick consumes it.
// Assumes: tick is a one-cycle strobe in the clk domain.
module pit_gate_capture #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gate_in,
    input  logic tick,
    output logic gate_lvl,
    output logic gate_trig
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   lvl_d_q;
    logic                   edge_q;
    logic                   rise;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            // Single-flop synchroniser variant.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= gate_in;
            end
        end else begin : g_chain
            // Multi-flop synchroniser chain.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], gate_in};
            end
        end
    endgenerate

    assign gate_lvl = sync_q[SYNC_STAGES-1];
    assign rise     = gate_lvl & ~lvl_d_q;

    // Delayed level for edge detection, and the sticky trigger flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_d_q <= 1'b0;
            edge_q  <= 1'b0;
        end else begin
            lvl_d_q <= gate_lvl;
            if (rise)      edge_q <= 1'b1;
            else if (tick) edge_q <= 1'b0;
        end
    end

    assign gate_trig = edge_q;
endmodule

// File: rtl/pit_decrement.sv
`timescale 1ns/1ps
// Combinational decrement by one, in binary or in packed decimal digits.
// Assumes: in BCD use every digit of val is 0..9.
module pit_decrement #(
    parameter int DIGITS = 4,
    localparam int CNT_W = 4 * DIGITS
) (
    input  logic [CNT_W-1:0] val,
    input  logic             bcd,
    output logic [CNT_W-1:0] nxt
);
    logic [DIGITS-1:0] borrow;
    logic [CNT_W-1:0]  dec_val;

    assign borrow[0] = 1'b1;

    generate
        for (genvar i = 0; i < DIGITS; i++) begin : g_digit
            logic [3:0] dig;
            assign dig = val[4*i +: 4];
            assign dec_val[4*i +: 4] = borrow[i] ? ((dig == 4'd0) ? 4'd9 : dig - 4'd1) : dig;
            if (i < DIGITS - 1) begin : g_chain
                assign borrow[i+1] = borrow[i] & (dig == 4'd0);
            end
        end
    endgenerate

    assign nxt = bcd ? dec_val : (val - {{(CNT_W-1){1'b0}}, 1'b1});
endmodule

// File: rtl/pit_channel.sv
`timescale 1ns/1ps
// One interval counter channel with modes 0, 1, 2, 4 and 5.
// The count register takes host byte writes. The counting element loads and
// decrements on cnt_tick. OUT follows the rules of the selected mode.
// Assumes: a host write and a tick never fall in the same cycle (if they do,
// the write wins). cnt_tick marks one completed counter clock pulse.
module pit_channel
    import pit_pkg::*;
#(
    parameter int DIGITS    = 4,
    parameter int GATE_SYNC = 2,
    localparam int CNT_W    = 4 * DIGITS,
    localparam int BYTE_W   = CNT_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cw_wr,
    input  logic [2:0]        cw_mode,
    input  logic              cw_bcd,
    input  logic [1:0]        cw_access,
    input  logic              cnt_wr,
    input  logic [BYTE_W-1:0] cnt_data,
    input  logic              cnt_tick,
    input  logic              gate,
    output logic              out,
    output logic              null_cnt,
    output logic [CNT_W-1:0]  live_count
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    pit_mode_e         mode_q;
    pit_access_e       acc_q;
    logic              bcd_q;
    logic [CNT_W-1:0]  cr_q, ce_q, ce_nxt, wr_val;
    logic [BYTE_W-1:0] lo_q;
    logic              hi_phase_q, hold_q, pend_q, have_q, run_q, fired_q;
    logic              out_q, null_q;
    logic              wr_first, wr_done;
    logic              gate_lvl, gate_trig;

    pit_gate_capture #(.SYNC_STAGES(GATE_SYNC)) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .gate_in  (gate),
        .tick     (cnt_tick),
        .gate_lvl (gate_lvl),
        .gate_trig(gate_trig)
    );

    pit_decrement #(.DIGITS(DIGITS)) u_dec (
        .val(ce_q),
        .bcd(bcd_q),
        .nxt(ce_nxt)
    );

    // Decode a count byte write against the access format.
    always_comb begin
        wr_first = 1'b0;
        wr_done  = 1'b0;
        wr_val   = cr_q;
        if (cnt_wr) begin
            case (acc_q)
                AC_HIGH: begin
                    wr_done = 1'b1;
                    wr_val  = {cnt_data, {BYTE_W{1'b0}}};
                end
                AC_BOTH: begin
                    if (!hi_phase_q) begin
                        wr_first = 1'b1;
                    end else begin
                        wr_done = 1'b1;
                        wr_val  = {cnt_data, lo_q};
                    end
                end
                default: begin
                    wr_done = 1'b1;
                    wr_val  = {{BYTE_W{1'b0}}, cnt_data};
                end
            endcase
        end
    end

    // Channel state: control word, count writes, tick processing per mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q     <= MD_RSV7;
            acc_q      <= AC_LOW;
            bcd_q      <= 1'b0;
            cr_q       <= '0;
            ce_q       <= '0;
            lo_q       <= '0;
            hi_phase_q <= 1'b0;
            hold_q     <= 1'b0;
            pend_q     <= 1'b0;
            have_q     <= 1'b0;
            run_q      <= 1'b0;
            fired_q    <= 1'b0;
            out_q      <= 1'b1;
            null_q     <= 1'b0;
        end else if (cw_wr) begin
            mode_q     <= pit_mode_e'(cw_mode);
            acc_q      <= pit_access_e'(cw_access);
            bcd_q      <= cw_bcd;
            out_q      <= (cw_mode != 3'd0);
            null_q     <= 1'b1;
            hi_phase_q <= 1'b0;
            hold_q     <= 1'b0;
            pend_q     <= 1'b0;
            have_q     <= 1'b0;
            run_q      <= 1'b0;
            fired_q    <= 1'b0;
        end else begin
            if (cnt_tick) begin
                case (mode_q)
                    MD_TERM: begin
                        if (pend_q) begin
                            ce_q   <= cr_q;
                            pend_q <= 1'b0;
                            null_q <= 1'b0;
                            run_q  <= 1'b1;
                        end else if (run_q && gate_lvl && !hold_q) begin
                            ce_q <= ce_nxt;
                            if (ce_q == ONE) out_q <= 1'b1;
                        end
                    end
                    MD_ONESHOT: begin
                        if (gate_trig && have_q) begin
                            ce_q   <= cr_q;
                            null_q <= 1'b0;
                            run_q  <= 1'b1;
                            out_q  <= 1'b0;
                        end else if (run_q) begin
                            ce_q <= ce_nxt;
                            if (ce_q == ONE) out_q <= 1'b1;
                        end
                    end
                    MD_RATE: begin
                        if ((pend_q || gate_trig) && have_q) begin
                            ce_q   <= cr_q;
                            pend_q <= 1'b0;
                            null_q <= 1'b0;
                            run_q  <= 1'b1;
                            out_q  <= 1'b1;
                        end else if (run_q && gate_lvl) begin
                            if (ce_q == ONE) begin
                                ce_q   <= cr_q;
                                null_q <= 1'b0;
                                out_q  <= 1'b1;
                            end else begin
                                ce_q  <= ce_nxt;
                                out_q <= (ce_nxt != ONE);
                            end
                        end
                    end
                    MD_SWSTROBE, MD_HWSTROBE: begin
                        if ((mode_q == MD_SWSTROBE) ? pend_q : (gate_trig && have_q)) begin
                            ce_q    <= cr_q;
                            pend_q  <= 1'b0;
                            null_q  <= 1'b0;
                            run_q   <= 1'b1;
                            fired_q <= 1'b0;
                            out_q   <= 1'b1;
                        end else if (run_q && (gate_lvl || mode_q == MD_HWSTROBE)) begin
                            ce_q <= ce_nxt;
                            if (ce_q == ONE && !fired_q) begin
                                out_q   <= 1'b0;
                                fired_q <= 1'b1;
                            end else begin
                                out_q <= 1'b1;
                            end
                        end
                    end
                    default: out_q <= 1'b1;
                endcase
            end

            // A low gate in rate mode forces the output high without a tick.
            if (mode_q == MD_RATE && !gate_lvl) out_q <= 1'b1;

            if (wr_first) begin
                lo_q       <= cnt_data;
                hi_phase_q <= 1'b1;
                if (mode_q == MD_TERM) begin
                    hold_q <= 1'b1;
                    pend_q <= 1'b0;
                    out_q  <= 1'b0;
                end
            end

            if (wr_done) begin
                cr_q       <= wr_val;
                hi_phase_q <= 1'b0;
                hold_q     <= 1'b0;
                null_q     <= 1'b1;
                have_q     <= 1'b1;
                case (mode_q)
                    MD_TERM: begin
                        pend_q <= 1'b1;
                        out_q  <= 1'b0;
                    end
                    MD_SWSTROBE: pend_q <= 1'b1;
                    MD_RATE:     if (!run_q) pend_q <= 1'b1;
                    default: ;
                endcase
            end
        end
    end

    assign out        = out_q;
    assign null_cnt   = null_q;
    assign live_count = ce_q;
endmodule

// File: rtl/pit_channel_chk.sv
`timescale 1ns/1ps
// Property checker for pit_channel, attached by bind below.
module pit_channel_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cw_wr,
    input logic [2:0]       cw_mode,
    input logic             cnt_tick,
    input logic             out,
    input logic             null_cnt,
    input logic [CNT_W-1:0] live_count,
    input logic [2:0]       mode_q,
    input logic             gate_lvl
);
    // R1: a control word sets the initial output level on the next clock
    a_r1_cw_out_level: assert property (@(posedge clk) disable iff (!rst_n)
        cw_wr |=> (out == ($past(cw_mode) != 3'd0)));

    // R11: a control word sets null count
    a_r11_cw_sets_null: assert property (@(posedge clk) disable iff (!rst_n)
        cw_wr |=> null_cnt);

    // R11: null count clears only through a transfer on a tick
    a_r11_null_clears_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(null_cnt) |-> $past(cnt_tick));

    // R13: the counting element moves only on ticks
    a_r13_count_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_tick |=> $stable(live_count));

    // R6: a low gate in rate mode holds the output high
    a_r6_gate_low_forces_high: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 3'd2 && !gate_lvl && !cw_wr) |=> out);

    // R3: in mode 0 the output rises only on a tick
    a_r3_m0_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 3'd0 && $past(mode_q) == 3'd0 && $rose(out)) |-> $past(cnt_tick));
endmodule

bind pit_channel pit_channel_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cw_wr     (cw_wr),
    .cw_mode   (cw_mode),
    .cnt_tick  (cnt_tick),
    .out       (out),
    .null_cnt  (null_cnt),
    .live_count(live_count),
    .mode_q    (mode_q),
    .gate_lvl  (gate_lvl)
);

// File: tb/pit_channel_tb.sv
`timescale 1ns/1ps
// Directed bench for pit_channel: one task per scenario.
module pit_channel_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cw_wr = 1'b0;
    logic [2:0]  cw_mode = 3'd0;
    logic        cw_bcd = 1'b0;
    logic [1:0]  cw_access = 2'd1;
    logic        cnt_wr = 1'b0;
    logic [7:0]  cnt_data = 8'd0;
    logic        cnt_tick = 1'b0;
    logic        gate = 1'b0;
    logic        out;
    logic        null_cnt;
    logic [15:0] live_count;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pit_channel u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cw_wr     (cw_wr),
        .cw_mode   (cw_mode),
        .cw_bcd    (cw_bcd),
        .cw_access (cw_access),
        .cnt_wr    (cnt_wr),
        .cnt_data  (cnt_data),
        .cnt_tick  (cnt_tick),
        .gate      (gate),
        .out       (out),
        .null_cnt  (null_cnt),
        .live_count(live_count)
    );

    task automatic chk(input string what, input logic [15:0] act, input logic [15:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk) cnt_tick = 1'b1;
        @(negedge clk) cnt_tick = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic set_gate(input logic v);
        @(negedge clk) gate = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic ctrl(input logic [2:0] m, input logic b, input logic [1:0] a);
        @(negedge clk);
        cw_mode = m; cw_bcd = b; cw_access = a; cw_wr = 1'b1;
        @(negedge clk) cw_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic wbyte(input logic [7:0] d);
        @(negedge clk);
        cnt_data = d; cnt_wr = 1'b1;
        @(negedge clk) cnt_wr = 1'b0;
        @(negedge clk);
    endtask

    // Set the gate and let a tick consume any stale edge.
    task automatic prep(input logic g);
        set_gate(g);
        tick();
    endtask

    task automatic t_reset();
        chk("R1 reset out", {15'd0, out}, 16'd1);
        chk("R11 reset null", {15'd0, null_cnt}, 16'd0);
        chk("R13 reset count", live_count, 16'h0000);
    endtask

    task automatic t_mode0();
        prep(1'b1);
        ctrl(3'd0, 1'b0, 2'd1);
        chk("R1 mode0 out low after cw", {15'd0, out}, 16'd0);
        chk("R11 null set by cw", {15'd0, null_cnt}, 16'd1);
        wbyte(8'd3);
        tick();
        chk("R2 load tick no decrement", live_count, 16'd3);
        chk("R11 null cleared on load", {15'd0, null_cnt}, 16'd0);
        tick(); tick();
        chk("R3 out low before terminal", {15'd0, out}, 16'd0);
        tick();
        chk("R3 count at zero", live_count, 16'd0);
        chk("R3 out high at N+1", {15'd0, out}, 16'd1);
        tick();
        chk("R9 binary wrap", live_count, 16'hFFFF);
        chk("R3 out stays high", {15'd0, out}, 16'd1);
        set_gate(1'b0);
        tick();
        chk("R3 gate low holds count", live_count, 16'hFFFF);
    endtask

    task automatic t_mode0_two_byte();
        prep(1'b1);
        ctrl(3'd0, 1'b0, 2'd3);
        wbyte(8'h05);
        chk("R11 null not set by low byte alone", {15'd0, null_cnt}, 16'd1);
        wbyte(8'h00);
        for (int i = 0; i < 6; i++) tick();
        chk("R3 two-byte count at zero", live_count, 16'd0);
        chk("R3 two-byte out high", {15'd0, out}, 16'd1);
        wbyte(8'h02);
        chk("R4 low byte forces out low", {15'd0, out}, 16'd0);
        chk("R11 low byte leaves null clear", {15'd0, null_cnt}, 16'd0);
        tick();
        chk("R4 low byte freezes count", live_count, 16'd0);
        wbyte(8'h00);
        chk("R11 null set after high byte", {15'd0, null_cnt}, 16'd1);
        tick();
        chk("R4 high byte loads next tick", live_count, 16'd2);
        tick(); tick();
        chk("R4 out high after reload", {15'd0, out}, 16'd1);
    endtask

    task automatic t_high_only();
        prep(1'b1);
        ctrl(3'd0, 1'b0, 2'd2);
        wbyte(8'h01);
        tick();
        chk("R2 high-only access", live_count, 16'h0100);
    endtask

    task automatic t_mode1();
        prep(1'b0);
        ctrl(3'd1, 1'b0, 2'd1);
        wbyte(8'd3);
        tick();
        chk("R5 no trigger out high", {15'd0, out}, 16'd1);
        set_gate(1'b1);
        tick();
        chk("R5 trigger loads", live_count, 16'd3);
        chk("R5 out low after trigger", {15'd0, out}, 16'd0);
        tick(); tick();
        chk("R5 out low before N", {15'd0, out}, 16'd0);
        tick();
        chk("R5 out high after N", {15'd0, out}, 16'd1);
        wbyte(8'd5);
        tick();
        chk("R5 new count waits for trigger", live_count, 16'hFFFF);
        set_gate(1'b0);
        set_gate(1'b1);
        tick();
        chk("R5 retrigger loads new count", live_count, 16'd5);
        chk("R5 retrigger out low", {15'd0, out}, 16'd0);
    endtask

    task automatic t_mode2();
        prep(1'b1);
        ctrl(3'd2, 1'b0, 2'd1);
        wbyte(8'd3);
        tick();
        chk("R6 load", live_count, 16'd3);
        tick();
        chk("R6 out high mid period", {15'd0, out}, 16'd1);
        tick();
        chk("R6 out low at count 1", {15'd0, out}, 16'd0);
        tick();
        chk("R6 reload", live_count, 16'd3);
        chk("R6 out high after reload", {15'd0, out}, 16'd1);
        tick(); tick();
        chk("R6 second period low", {15'd0, out}, 16'd0);
        set_gate(1'b0);
        chk("R6 gate low forces high", {15'd0, out}, 16'd1);
        tick();
        chk("R6 gate low holds count", live_count, 16'd1);
        set_gate(1'b1);
        tick();
        chk("R6 gate rise reloads", live_count, 16'd3);
    endtask

    task automatic t_mode4();
        prep(1'b1);
        ctrl(3'd4, 1'b0, 2'd1);
        wbyte(8'd2);
        tick();
        chk("R7 load", live_count, 16'd2);
        tick();
        chk("R7 out high before strobe", {15'd0, out}, 16'd1);
        tick();
        chk("R7 strobe low at N+1", {15'd0, out}, 16'd0);
        tick();
        chk("R7 strobe one tick", {15'd0, out}, 16'd1);
        chk("R9 mode4 wraps", live_count, 16'hFFFF);
    endtask

    task automatic t_mode5();
        prep(1'b0);
        ctrl(3'd5, 1'b0, 2'd1);
        wbyte(8'd2);
        tick();
        chk("R11 null held without trigger", {15'd0, null_cnt}, 16'd1);
        chk("R8 out high idle", {15'd0, out}, 16'd1);
        set_gate(1'b1);
        tick();
        chk("R8 trigger loads", live_count, 16'd2);
        tick(); tick();
        chk("R8 strobe low", {15'd0, out}, 16'd0);
        tick();
        chk("R8 strobe ends", {15'd0, out}, 16'd1);
    endtask

    task automatic t_short_gate();
        prep(1'b0);
        ctrl(3'd5, 1'b0, 2'd1);
        wbyte(8'd4);
        set_gate(1'b1);
        set_gate(1'b0);
        tick();
        chk("R12 short gate pulse caught", live_count, 16'd4);
    endtask

    task automatic t_bcd();
        prep(1'b1);
        ctrl(3'd0, 1'b1, 2'd3);
        wbyte(8'h00);
        wbyte(8'h01);
        tick();
        chk("R10 bcd load", live_count, 16'h0100);
        tick();
        chk("R10 bcd borrow", live_count, 16'h0099);
        ctrl(3'd0, 1'b1, 2'd1);
        wbyte(8'h00);
        tick();
        chk("R9 bcd zero load", live_count, 16'h0000);
        tick();
        chk("R9 bcd wrap", live_count, 16'h9999);
    endtask

    task automatic t_reserved();
        prep(1'b1);
        ctrl(3'd3, 1'b0, 2'd1);
        chk("R1 reserved out high", {15'd0, out}, 16'd1);
        wbyte(8'd2);
        tick(); tick(); tick();
        chk("R1 reserved stays high", {15'd0, out}, 16'd1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_mode0();
        t_mode0_two_byte();
        t_high_only();
        t_mode1();
        t_mode2();
        t_mode4();
        t_mode5();
        t_short_gate();
        t_bcd();
        t_reserved();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule